// File: doc/BRIEF.md
# Stereo SRAM Audio Delay Sequencer

This block runs a stereo delay line held in an external asynchronous SRAM with a 16-bit data bus. A frame start pulse begins one audio frame. During the frame the block exchanges four bytes with a codec over a byte-wide serial shift port. Each exchange sends one byte of a delayed (wet) sample and receives one byte of a fresh (dry) sample. The byte exchanges are interleaved with SRAM cycles: a read that fetches the delayed sample for each channel, and a write that stores the newly arrived dry sample for each channel.

The block keeps a write pointer and a read pointer into the SRAM. Both pointers advance once per channel. At the end of every frame the read pointer is rebuilt as the write pointer minus the delay input, modulo the address space. Wet samples fetched in one frame are sent to the codec in the following frame. After the last SRAM write the block goes idle until the next frame start.

Top module: `sram_delay_seq`

## Requirements
- R1: Each frame issues exactly four byte loads (`spi_load_o` high for one cycle each). `spi_tx_o` carries, in this order, the left wet sample's upper byte, its lower byte, the right wet sample's upper byte and its lower byte. The wet samples are those read from SRAM in the previous frame, and both are zero after reset.
- R2: `lrclk_o` rises on frame start, is high while the first byte is loaded, and is low from the cycle after that load until the next frame.
- R3: A byte is not loaded until the `spi_done_i` pulse for the previous byte of the frame has been seen. `spi_done_i` may arrive while an SRAM cycle is in progress, and its byte is still kept.
- R4: An SRAM read drives the address with `sram_oe_no` low and samples `sram_rdata_i` two clock cycles later, keeping the address stable in between.
- R5: An SRAM write drives the address, pulls `sram_we_no` low, drives the data in the next cycle, and then raises `sram_we_no` while the data is still driven. The SRAM captures the data on that rising edge.
- R6: `sram_wdata_oe_o` drops in the cycle after `sram_we_no` rises. It is never high while `sram_oe_no` is low, and `sram_we_no` and `sram_oe_no` are never low together.
- R7: With W as the write pointer at frame start, the left dry sample is written at W+1 and the right one at W+2. With R as the read pointer at frame start, left reads from R+1 and right reads from R+2. Each read happens before the write in the same channel.
- R8: At frame end the read pointer becomes the write pointer minus `delay_i`, modulo 2^ADDR_W. A delay of 0 reads each address just before it is overwritten.
- R9: The first byte received for a channel is the upper byte of that channel's dry sample, and the second is the lower byte. Each dry sample is written only after both of its bytes have arrived.
- R10: When not in a frame the block is idle. A frame start that arrives during a frame is ignored, and no load occurs without a frame start.
- R11: After reset the outputs show `spi_load_o`=0, `lrclk_o`=0, `sram_we_no`=1, `sram_oe_no`=1 and `sram_wdata_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Starts one frame when idle |
| delay_i | input | ADDR_W | Delay in sample slots, sampled at frame end |
| spi_tx_o | output | BYTE_W | Byte to shift out, valid with spi_load_o |
| spi_load_o | output | 1 | One-cycle pulse that starts a byte transfer |
| spi_done_i | input | 1 | One-cycle pulse when a transfer has finished |
| spi_rx_i | input | BYTE_W | Received byte, valid with spi_done_i |
| lrclk_o | output | 1 | Left/right alignment clock to the codec |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_wdata_o | output | 2*BYTE_W | SRAM write data |
| sram_wdata_oe_o | output | 1 | Drive enable for the SRAM data bus |
| sram_rdata_i | input | 2*BYTE_W | SRAM read data |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |

## Verification
Each transmitted byte is valid in the same cycle as its load pulse, so the bench samples `spi_tx_o` at the falling edge of that cycle. The SRAM model returns valid read data only once the address has been held with output enable low through one full earlier cycle, so a read sampled at the first edge after the address changes would pick up a poison word. Writes are checked at the instant `sram_we_no` rises, against an address and value that the bench works out from its own copy of the pointers and memory. The effect of a frame's delay shows up only in the next frame's transmitted bytes, so each frame's expected values are computed from the delay applied at the end of the previous frame.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_WAIT, ST_RD, ST_WR0, ST_WR1, ST_WR2, ST_FIN
  } sds_state_e;
endpackage

// File: rtl/sds_ptr.sv
module sds_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_step_i,
  input  logic              wr_step_i,
  input  logic              sync_i,
  input  logic [ADDR_W-1:0] delay_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic [ADDR_W-1:0] rd_ptr_o
);
  logic [ADDR_W-1:0] w_q, r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0;
      r_q <= '0;
    end else if (start_i) begin
      w_q <= w_q + 1'b1;
      r_q <= r_q + 1'b1;
    end else begin
      if (wr_step_i) w_q <= w_q + 1'b1;
      if (rd_step_i) r_q <= r_q + 1'b1;
      else if (sync_i) r_q <= w_q - delay_i;  // wraps modulo 2^ADDR_W
    end
  end

  assign wr_ptr_o = w_q;
  assign rd_ptr_o = r_q;
endmodule

// File: rtl/sds_rx_latch.sv
module sds_rx_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic              seen_o,
  output logic [BYTE_W-1:0] byte_o
);
  // holds a done pulse that lands while an SRAM cycle is busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_o <= 1'b0;
      byte_o <= '0;
    end else if (load_i) begin
      seen_o <= 1'b0;
    end else if (done_i) begin
      seen_o <= 1'b1;
      byte_o <= rx_i;
    end
  end
endmodule

// File: rtl/sds_ctrl.sv
module sds_ctrl
  import sds_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int RD_WAIT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic                rx_seen_i,
  input  logic [BYTE_W-1:0]   rx_byte_i,
  input  logic [ADDR_W-1:0]   wr_ptr_i,
  input  logic [ADDR_W-1:0]   rd_ptr_i,
  input  logic [2*BYTE_W-1:0] rdata_i,
  output logic                start_o,
  output logic                rd_step_o,
  output logic                wr_step_o,
  output logic                sync_o,
  output logic                load_o,
  output logic [BYTE_W-1:0]   tx_o,
  output logic                lrclk_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [2*BYTE_W-1:0] wdata_o,
  output logic                wdata_oe_o,
  output logic                we_no,
  output logic                oe_no
);
  localparam int DW = 2 * BYTE_W;
  localparam int CW = $clog2(RD_WAIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(RD_WAIT - 1);

  sds_state_e state_q;
  logic [1:0]    step_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] wet_l_q, wet_r_q, dry_l_q, dry_r_q;
  logic          rd_last;

  assign rd_last   = (state_q == ST_RD) && (cnt_q == CNT_LAST);
  assign start_o   = (state_q == ST_IDLE) && frame_start_i;
  assign rd_step_o = rd_last && (step_q == 2'd1);
  assign wr_step_o = (state_q == ST_WR2) && (step_q == 2'd2);
  assign sync_o    = (state_q == ST_FIN);
  assign load_o    = (state_q == ST_LOAD);

  always_comb begin
    unique case (step_q)
      2'd0:    tx_o = wet_l_q[DW-1:BYTE_W];
      2'd1:    tx_o = wet_l_q[BYTE_W-1:0];
      2'd2:    tx_o = wet_r_q[DW-1:BYTE_W];
      default: tx_o = wet_r_q[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      cnt_q      <= '0;
      wet_l_q    <= '0;
      wet_r_q    <= '0;
      dry_l_q    <= '0;
      dry_r_q    <= '0;
      lrclk_o    <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
      wdata_oe_o <= 1'b0;
      we_no      <= 1'b1;
      oe_no      <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (frame_start_i) begin
          lrclk_o <= 1'b1;
          step_q  <= '0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (step_q == 2'd0) lrclk_o <= 1'b0;
          unique case (step_q)
            2'd1, 2'd3: begin
              addr_o  <= rd_ptr_i;
              oe_no   <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_RD;
            end
            2'd2: begin
              addr_o  <= wr_ptr_i;
              we_no   <= 1'b0;
              state_q <= ST_WR0;
            end
            default: state_q <= ST_WAIT;
          endcase
        end
        ST_RD: begin
          if (cnt_q == CNT_LAST) begin
            if (step_q == 2'd1) wet_l_q <= rdata_i;
            else                wet_r_q <= rdata_i;
            oe_no   <= 1'b1;
            state_q <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WR0: begin
          wdata_o    <= (step_q == 2'd2) ? dry_l_q : dry_r_q;
          wdata_oe_o <= 1'b1;
          state_q    <= ST_WR1;
        end
        ST_WR1: begin
          we_no   <= 1'b1;  // capture edge, data still driven
          state_q <= ST_WR2;
        end
        ST_WR2: begin
          wdata_oe_o <= 1'b0;
          state_q    <= (step_q == 2'd3) ? ST_FIN : ST_WAIT;
        end
        ST_WAIT: if (rx_seen_i) begin
          unique case (step_q)
            2'd0:    dry_l_q[DW-1:BYTE_W] <= rx_byte_i;
            2'd1:    dry_l_q[BYTE_W-1:0]  <= rx_byte_i;
            2'd2:    dry_r_q[DW-1:BYTE_W] <= rx_byte_i;
            default: dry_r_q[BYTE_W-1:0]  <= rx_byte_i;
          endcase
          if (step_q == 2'd3) begin
            addr_o  <= wr_ptr_i;
            we_no   <= 1'b0;
            state_q <= ST_WR0;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;  // ST_FIN
      endcase
    end
  end
endmodule

// File: rtl/sram_delay_seq.sv
module sram_delay_seq #(
  parameter int ADDR_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int RD_WAIT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic [ADDR_W-1:0]   delay_i,
  output logic [BYTE_W-1:0]   spi_tx_o,
  output logic                spi_load_o,
  input  logic                spi_done_i,
  input  logic [BYTE_W-1:0]   spi_rx_i,
  output logic                lrclk_o,
  output logic [ADDR_W-1:0]   sram_addr_o,
  output logic [2*BYTE_W-1:0] sram_wdata_o,
  output logic                sram_wdata_oe_o,
  input  logic [2*BYTE_W-1:0] sram_rdata_i,
  output logic                sram_we_no,
  output logic                sram_oe_no
);
  logic              start, rd_step, wr_step, sync, rx_seen;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;

  sds_rx_latch #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(spi_load_o), .done_i(spi_done_i),
    .rx_i(spi_rx_i), .seen_o(rx_seen), .byte_o(rx_byte)
  );

  sds_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .rd_step_i(rd_step),
    .wr_step_i(wr_step), .sync_i(sync), .delay_i(delay_i),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr)
  );

  sds_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .RD_WAIT(RD_WAIT)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .rx_seen_i(rx_seen), .rx_byte_i(rx_byte), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
    .rdata_i(sram_rdata_i), .start_o(start), .rd_step_o(rd_step),
    .wr_step_o(wr_step), .sync_o(sync), .load_o(spi_load_o), .tx_o(spi_tx_o),
    .lrclk_o(lrclk_o), .addr_o(sram_addr_o), .wdata_o(sram_wdata_o),
    .wdata_oe_o(sram_wdata_oe_o), .we_no(sram_we_no), .oe_no(sram_oe_no)
  );
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_load_o,
  input logic              lrclk_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_wdata_oe_o,
  input logic              sram_we_no,
  input logic              sram_oe_no
);
  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_wdata_oe_o |-> sram_oe_no);

  a_r6_we_oe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));

  a_r5_data_at_we_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_wdata_oe_o);

  a_r6_release_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |=> !sram_wdata_oe_o);

  a_r4_read_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_oe_no) |=> (!sram_oe_no && $stable(sram_addr_o)));

  a_r2_lrclk_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_load_o && lrclk_o) |=> !lrclk_o);

  a_r3_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_load_o |=> !spi_load_o);
endmodule

bind sram_delay_seq sds_checker #(.ADDR_W(ADDR_W)) u_sds_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .spi_load_o(spi_load_o), .lrclk_o(lrclk_o),
  .sram_addr_o(sram_addr_o), .sram_wdata_oe_o(sram_wdata_oe_o),
  .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no)
);

// File: tb/sram_delay_seq_bench.sv
module sram_delay_seq_bench;
  localparam int AW = 8;
  localparam int BW = 8;
  localparam int DW = 16;
  localparam int NFR = 300;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_start = 1'b0;
  logic [AW-1:0] delay = '0;
  logic [BW-1:0] tx, rx = '0;
  logic load, done = 1'b0, lrclk;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic wdata_oe, we_n, oe_n;

  always #10 clk = ~clk;

  sram_delay_seq #(.ADDR_W(AW), .BYTE_W(BW), .RD_WAIT(2)) u_sram_delay_seq (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start), .delay_i(delay),
    .spi_tx_o(tx), .spi_load_o(load), .spi_done_i(done), .spi_rx_i(rx),
    .lrclk_o(lrclk), .sram_addr_o(addr), .sram_wdata_o(wdata),
    .sram_wdata_oe_o(wdata_oe), .sram_rdata_i(rdata), .sram_we_no(we_n),
    .sram_oe_no(oe_n)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 257) ^ 16'h5A3C;
  endfunction

  function automatic logic [DW-1:0] dry_word(input int n, input int c);
    return DW'(n * 613 + c * 4099 + 17);
  endfunction

  // SRAM model: data valid only after address held with OE low for a full cycle (R4)
  logic [DW-1:0] mem [2**AW];
  logic [AW-1:0] prev_addr = '0;
  logic prev_oe_low = 1'b0, ready = 1'b0;
  initial for (int a = 0; a < 2**AW; a++) mem[a] = init_word(a);
  always @(negedge clk) begin
    ready = (addr == prev_addr) && !oe_n && prev_oe_low;
    prev_addr = addr;
    prev_oe_low = !oe_n;
  end
  assign rdata = (ready && !oe_n && we_n) ? mem[addr] : 16'hDEAD;

  // expected model
  logic [DW-1:0] exp_mem [2**AW];
  logic [AW-1:0] w_e = '0, r_e = '0;
  logic [DW-1:0] wet_l = '0, wet_r = '0;
  logic [BW-1:0] etx [4];
  logic [AW-1:0] ewa [2];
  logic [DW-1:0] ewd [2];
  int wr_idx = 0;
  logic active = 1'b0;
  initial for (int a = 0; a < 2**AW; a++) exp_mem[a] = init_word(a);

  // write monitor: R5 address/data at WE rise, R7 addresses, R9 dry assembly
  always @(posedge we_n) begin
    if (rst_ni && active) begin
      if (wr_idx < 2) begin
        chk(wdata_oe, "R5 data driven at WE rise", 32'(wdata_oe), 1);
        chk(addr == ewa[wr_idx], "R7 write address", 32'(addr), 32'(ewa[wr_idx]));
        chk(wdata == ewd[wr_idx], "R9 write data", 32'(wdata), 32'(ewd[wr_idx]));
        if (wdata_oe) mem[addr] = wdata;
      end else begin
        chk(1'b0, "R1 extra write", 32'(wr_idx), 2);
      end
      wr_idx++;
    end
  end

  // contention monitor R6
  always @(negedge clk) begin
    if (rst_ni && wdata_oe && !oe_n) chk(1'b0, "R6 bus contention", 1, 0);
  end

  task automatic run_frame(input int n, input logic [AW-1:0] d);
    logic [DW-1:0] dl, dr, rd_l, rd_r;
    logic [BW-1:0] bytes [4];
    logic early;
    dl = dry_word(n, 0);
    dr = dry_word(n, 1);
    bytes[0] = dl[15:8]; bytes[1] = dl[7:0]; bytes[2] = dr[15:8]; bytes[3] = dr[7:0];
    w_e = w_e + 1'b1; r_e = r_e + 1'b1;
    etx[0] = wet_l[15:8]; etx[1] = wet_l[7:0];
    rd_l = exp_mem[r_e]; r_e = r_e + 1'b1;
    ewa[0] = w_e; ewd[0] = dl; exp_mem[w_e] = dl; w_e = w_e + 1'b1;
    etx[2] = wet_r[15:8]; etx[3] = wet_r[7:0];
    rd_r = exp_mem[r_e];
    ewa[1] = w_e; ewd[1] = dr; exp_mem[w_e] = dr;
    r_e = w_e - d;  // R8
    wet_l = rd_l; wet_r = rd_r;

    wr_idx = 0;
    active = 1'b1;
    delay = d;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int t = 0;
      while (!load && t < 50) begin @(negedge clk); t++; end
      chk(load, "R1 byte load issued", 32'(load), 1);
      chk(tx == etx[k], "R1 transmitted byte", 32'(tx), 32'(etx[k]));
      chk(lrclk == (k == 0), "R2 alignment clock at load", 32'(lrclk), 32'(k == 0));
      early = 1'b0;
      for (int i = 0; i < 1 + (n + k) % 5; i++) begin
        @(negedge clk);
        frame_start = (n % 7 == 3) && (k == 1) && (i == 0);  // R10 ignored mid-frame
        if (load) early = 1'b1;
      end
      frame_start = 1'b0;
      chk(!early, "R3 no load before done", 32'(early), 0);
      done = 1'b1; rx = bytes[k];
      @(negedge clk) done = 1'b0;
    end
    repeat (12) @(negedge clk);
    chk(wr_idx == 2, "R1 two writes per frame", 32'(wr_idx), 2);
    chk(!load && !lrclk && we_n && oe_n && !wdata_oe, "R10 idle after frame",
        {27'b0, load, lrclk, we_n, oe_n, wdata_oe}, 32'b00110);
    active = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!load && !lrclk && we_n && oe_n && !wdata_oe, "R11 reset state",
        {27'b0, load, lrclk, we_n, oe_n, wdata_oe}, 32'b00110);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    for (int n = 0; n < NFR; n++) begin
      logic [AW-1:0] d;
      case (n % 6)
        0: d = '0;
        1: d = '1;
        2: d = AW'(1);
        default: d = AW'(n * 29 + 3);
      endcase
      run_frame(n, d);
      if (n % 50 == 10) begin
        logic seen;
        seen = 1'b0;
        repeat (20) begin @(negedge clk); if (load) seen = 1'b1; end
        chk(!seen, "R10 no load without frame start", 32'(seen), 0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule